// File: doc/BRIEF.md
# Half-Duplex Synchronous Serial Shifter

This block moves bytes over one shared serial data line and drives the shift clock for that line itself. Its parallel side has a byte input with a valid/ready handshake and a byte output with a valid/ready handshake. Its pin side has a clock output, a data output with an output enable, and a data input. A transmit enable or a receive enable picks the direction of each byte. Transmit wins when both are raised.

Each byte is eight bits, least significant bit first. In transmit, a new bit is put on the line when the shift clock falls. In receive, the line is sampled when the shift clock rises. The clock rests high when no byte is moving. A 13-bit reload counter sets the clock rate. It counts down from a programmed value and flips the clock phase each time it wraps. Back-to-back bytes are separated by one extra full clock period of quiet line.

A one-byte transmit buffer lets software queue the next byte while the current one shifts out. On the receive side, a byte waits for the consumer. If a new byte arrives before the held one was taken, a sticky overrun flag is set.

Top module: `half_duplex_shifter`

## Requirements
- R1: While reset (active-low, synchronous) is held and after it is released, the shift clock output is high, the data output enable is low, txReady is high, and rxValid, txEmpty and overrun are low.
- R2: While a byte is being moved, every phase (high or low) of the shift clock lasts exactly reload+1 system clock cycles.
- R3: A transmitted byte appears on dataOut least significant bit first. Each bit changes only with a falling shift-clock edge and is stable across the following rising edge.
- R4: In receive, dataIn is sampled at each rising shift-clock edge, least significant bit first. The completed byte is presented on rxData with rxValid high.
- R5: For back-to-back bytes in either direction, the time from the last rising edge of one byte to the first falling edge of the next is 3*(reload+1) system cycles, which is one extra full shift-clock period.
- R6: The transmit buffer holds one byte. txReady goes low in the cycle after a byte is accepted and stays low until the engine takes the byte. txEmpty pulses for one cycle each time the buffer is taken, so the number of pulses equals the number of bytes sent.
- R7: With both enables low, a buffered byte waits and the shift clock stays high. With both enables high, a buffered byte is transmitted and no byte is received. Receive runs only when transmit enable is low.
- R8: dataOe is high from the start of each transmitted byte through its trailing gap. It is low throughout reception and while idle.
- R9: rxValid, once high, stays high until a cycle in which rxReady is high. It falls in the next cycle.
- R10: If a byte completes while rxValid is high and rxReady is low, overrun is set and stays set until reset. The newer byte replaces the held one on rxData.
- R11: The full 13-bit reload range is honoured. A reload value in the hundreds gives the proportionally longer half period and gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| reload | input | 13 | Reload value of the shift-clock divider; half period = reload+1 cycles |
| txEn | input | 1 | Transmit enable; has priority over rxEn |
| rxEn | input | 1 | Receive enable |
| txData | input | 8 | Byte to transmit |
| txValid | input | 1 | txData is offered |
| txReady | output | 1 | Transmit buffer can take a byte |
| rxData | output | 8 | Last received byte |
| rxValid | output | 1 | rxData holds an unread byte |
| rxReady | input | 1 | Consumer takes rxData this cycle |
| txEmpty | output | 1 | One-cycle pulse when the buffered byte is taken for shifting |
| overrun | output | 1 | Sticky: a received byte was lost |
| sclkOut | output | 1 | Shift clock, high when idle |
| dataOut | output | 1 | Serial data driven onto the shared line |
| dataOe | output | 1 | Output enable for dataOut |
| dataIn | input | 1 | Serial data read from the shared line |

## Verification
The checks inside the design assume that reload is only changed while the engine is idle. They also assume that the data line is driven by an outside source only while dataOe is low. The stimulus writes reload only between resets. It drives dataIn only in receive runs, changing it at observed falling shift-clock edges. Enables are changed only while the engine is idle or within the quiet gap after a byte. This keeps the direction decision at each byte boundary well defined.

// File: rtl/hds_pkg.sv
package hds_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SHIFT = 2'd1,
    PH_GAP   = 2'd2
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadTx;    // move buffer into transmit shifter
    logic shiftOut;  // falling shift-clock edge while sending
    logic sampleIn;  // rising shift-clock edge while receiving
    logic rxFinish;  // final sample of a received byte
    logic txActive;  // a transmitted byte or its gap is in progress
  } strobe_t;

endpackage

// File: rtl/hds_baud.sv
module hds_baud #(
  parameter int RELOAD_W = 13
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                run,
  input  logic [RELOAD_W-1:0] reload,
  output logic                tick
);

  localparam logic [RELOAD_W-1:0] ONE = {{(RELOAD_W-1){1'b0}}, 1'b1};

  logic [RELOAD_W-1:0] cnt;

  assign tick = run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN || !run)     cnt <= reload;
    else if (cnt == '0)    cnt <= reload;
    else                   cnt <= cnt - ONE;
  end

  // R2: with a nonzero, steady reload, ticks are never adjacent
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rstN)
    ($past(tick) && reload != '0 && $stable(reload)) |-> !tick);

  // R11: the counter never exceeds a steady reload value while running
  a_r11_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    (run && $past(run) && $stable(reload)) |-> (cnt <= reload));

endmodule

// File: rtl/hds_ctrl.sv
module hds_ctrl
  import hds_pkg::*;
#(
  parameter int BITS = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    tick,
  input  logic    txEn,
  input  logic    rxEn,
  input  logic    bufFull,
  output logic    run,
  output logic    sclk,
  output strobe_t stb
);

  localparam int HALF_W = $clog2(2 * BITS);
  localparam logic [HALF_W-1:0] LAST_HALF = HALF_W'(2 * BITS - 1);
  localparam logic [HALF_W-1:0] ONE_HALF  = HALF_W'(1);

  phase_t            phase;
  logic [HALF_W-1:0] halfCnt;
  logic              gapSecond;
  logic              txMode;

  logic startTx, startRx, startAny, gapEnd, atLast;

  assign startTx  = txEn && bufFull;
  assign startRx  = rxEn && !txEn;
  assign startAny = startTx || startRx;
  assign gapEnd   = (phase == PH_GAP) && tick && gapSecond;
  assign atLast   = (halfCnt == LAST_HALF);
  assign run      = (phase != PH_IDLE);

  always_comb begin
    stb          = '0;
    stb.loadTx   = startTx && ((phase == PH_IDLE) || gapEnd);
    stb.shiftOut = (phase == PH_SHIFT) && tick && !halfCnt[0] && txMode;
    stb.sampleIn = (phase == PH_SHIFT) && tick && halfCnt[0] && !txMode;
    stb.rxFinish = stb.sampleIn && atLast;
    stb.txActive = txMode && (phase != PH_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      halfCnt   <= '0;
      gapSecond <= 1'b0;
      txMode    <= 1'b0;
      sclk      <= 1'b1;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          sclk <= 1'b1;
          if (startAny) begin
            phase   <= PH_SHIFT;
            txMode  <= startTx;
            halfCnt <= '0;
          end else begin
            txMode  <= 1'b0;
          end
        end
        PH_SHIFT: begin
          if (tick) begin
            sclk <= halfCnt[0];
            if (atLast) begin
              phase     <= PH_GAP;
              gapSecond <= 1'b0;
            end else begin
              halfCnt <= halfCnt + ONE_HALF;
            end
          end
        end
        PH_GAP: begin
          if (tick) begin
            if (gapSecond) begin
              halfCnt <= '0;
              txMode  <= startTx;
              phase   <= startAny ? PH_SHIFT : PH_IDLE;
            end else begin
              gapSecond <= 1'b1;
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R1: clock rests high whenever no byte is moving
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE) |-> sclk);

  // R5: the inter-byte gap keeps the clock high
  a_r5_gap_high: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_GAP) |-> sclk);

  // R2: the shift clock only changes after a divider tick
  a_r2_edge_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    (sclk != $past(sclk)) |-> $past(tick));

endmodule

// File: rtl/hds_datapath.sv
module hds_datapath
  import hds_pkg::*;
#(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         stb,
  input  logic [BITS-1:0] txData,
  input  logic            txValid,
  input  logic            rxReady,
  input  logic            dataIn,
  output logic            bufFull,
  output logic            txReady,
  output logic [BITS-1:0] rxData,
  output logic            rxValid,
  output logic            overrun,
  output logic            txEmpty,
  output logic            dataOut,
  output logic            dataOe
);

  logic [BITS-1:0] txBuf;
  logic [BITS-1:0] txSreg;
  logic [BITS-2:0] rxHold;

  assign txReady = !bufFull;
  assign dataOe  = stb.txActive;

  // transmit buffer and shifter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txBuf   <= '0;
      bufFull <= 1'b0;
      txSreg  <= '0;
      dataOut <= 1'b1;
      txEmpty <= 1'b0;
    end else begin
      txEmpty <= stb.loadTx;
      if (stb.loadTx) begin
        txSreg  <= txBuf;
        bufFull <= 1'b0;
      end else if (txValid && !bufFull) begin
        txBuf   <= txData;
        bufFull <= 1'b1;
      end
      if (stb.shiftOut) begin
        dataOut <= txSreg[0];
        txSreg  <= txSreg >> 1;
      end
    end
  end

  // receive shifter and holding register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxHold  <= '0;
      rxData  <= '0;
      rxValid <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (stb.sampleIn) rxHold <= {dataIn, rxHold[BITS-2:1]};
      if (stb.rxFinish) begin
        rxData  <= {dataIn, rxHold};
        rxValid <= 1'b1;
        if (rxValid && !rxReady) overrun <= 1'b1;
      end else if (rxValid && rxReady) begin
        rxValid <= 1'b0;
      end
    end
  end

  // R6: control only takes the buffer when it holds a byte
  a_r6_load_full: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadTx |-> bufFull);

  // R6: buffer-taken indication is a single-cycle pulse
  a_r6_empty_pulse: assert property (@(posedge clk) disable iff (!rstN)
    txEmpty |=> !txEmpty);

  // R9: an unread byte is not withdrawn
  a_r9_rx_hold: assert property (@(posedge clk) disable iff (!rstN)
    $past(rxValid && !rxReady) |-> rxValid);

  // R10: overrun is sticky
  a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    $past(overrun) |-> overrun);

endmodule

// File: rtl/half_duplex_shifter.sv
module half_duplex_shifter
  import hds_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int RELOAD_W = 13
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [RELOAD_W-1:0] reload,
  input  logic                txEn,
  input  logic                rxEn,
  input  logic [DATA_W-1:0]   txData,
  input  logic                txValid,
  output logic                txReady,
  output logic [DATA_W-1:0]   rxData,
  output logic                rxValid,
  input  logic                rxReady,
  output logic                txEmpty,
  output logic                overrun,
  output logic                sclkOut,
  output logic                dataOut,
  output logic                dataOe,
  input  logic                dataIn
);

  logic    run;
  logic    tick;
  logic    bufFull;
  strobe_t stb;

  hds_baud #(.RELOAD_W(RELOAD_W)) u_baud (
    .clk    (clk),
    .rstN   (rstN),
    .run    (run),
    .reload (reload),
    .tick   (tick)
  );

  hds_ctrl #(.BITS(DATA_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .tick    (tick),
    .txEn    (txEn),
    .rxEn    (rxEn),
    .bufFull (bufFull),
    .run     (run),
    .sclk    (sclkOut),
    .stb     (stb)
  );

  hds_datapath #(.BITS(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .txData  (txData),
    .txValid (txValid),
    .rxReady (rxReady),
    .dataIn  (dataIn),
    .bufFull (bufFull),
    .txReady (txReady),
    .rxData  (rxData),
    .rxValid (rxValid),
    .overrun (overrun),
    .txEmpty (txEmpty),
    .dataOut (dataOut),
    .dataOe  (dataOe)
  );

  // R8: the line is never driven while a byte is being received
  a_r8_no_drive_rx: assert property (@(posedge clk) disable iff (!rstN)
    (stb.sampleIn || stb.rxFinish) |-> !dataOe);

endmodule

// File: tb/half_duplex_shifter_bench.sv
`timescale 1ns/1ps
module half_duplex_shifter_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [12:0] reload = '0;
  logic        txEn = 1'b0, rxEn = 1'b0;
  logic [7:0]  txData = '0;
  logic        txValid = 1'b0;
  logic        txReady;
  logic [7:0]  rxData;
  logic        rxValid;
  logic        rxReady = 1'b0;
  logic        txEmpty, overrun, sclkOut, dataOut, dataOe;
  logic        dataIn;

  always #4 clk = ~clk;

  half_duplex_shifter u_half_duplex_shifter (
    .clk(clk), .rstN(rstN), .reload(reload), .txEn(txEn), .rxEn(rxEn),
    .txData(txData), .txValid(txValid), .txReady(txReady),
    .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady),
    .txEmpty(txEmpty), .overrun(overrun), .sclkOut(sclkOut),
    .dataOut(dataOut), .dataOe(dataOe), .dataIn(dataIn)
  );

  int nChecks = 0, nFails = 0, cyc = 0;
  int rl = 0;
  logic gapChk = 1'b0, txMon = 1'b0, rxMon = 1'b0;
  int txMul = 1, txAdd = 0, rxMul = 1, rxAdd = 0;

  // monitor state
  logic prevSclk;
  int lastEdge, bitCnt, edgeCnt, riseCnt, emptyCnt, nSeen, nGot, rxBitIdx;
  logic haveByte;
  logic [7:0] cap;
  logic [7:0] txSeen [0:511];
  logic [7:0] rxGot  [0:511];

  function automatic logic [7:0] txPat(int i);
    return 8'((i * txMul + txAdd) & 255);
  endfunction
  function automatic logic [7:0] rxPat(int i);
    return 8'((i * rxMul + rxAdd) & 255);
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      nFails++;
      $display("FAIL watchdog: actual %0d expected below 190000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  // pin monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (!rstN) begin
      prevSclk = 1'b1; lastEdge = cyc; bitCnt = 0; edgeCnt = 0; riseCnt = 0;
      emptyCnt = 0; nSeen = 0; nGot = 0; rxBitIdx = 0; haveByte = 1'b0;
      cap = '0; dataIn = 1'b0;
    end else begin
      if (txEmpty) emptyCnt++;
      if (rxValid && rxReady) begin
        rxGot[nGot] = rxData;
        nGot++;
      end
      if (sclkOut != prevSclk) begin
        edgeCnt++;
        if (!sclkOut) begin
          if (bitCnt != 0)
            chk(cyc - lastEdge == rl + 1, "R2 low-going half period", cyc - lastEdge, rl + 1);
          else if (gapChk && haveByte)
            chk(cyc - lastEdge == 3 * (rl + 1), "R5 inter-byte gap", cyc - lastEdge, 3 * (rl + 1));
          if (rxMon) begin
            dataIn = rxPat(rxBitIdx / 8)[rxBitIdx % 8];
            rxBitIdx++;
          end
        end else begin
          chk(cyc - lastEdge == rl + 1, "R2 high-going half period", cyc - lastEdge, rl + 1);
          riseCnt++;
          if (txMon) chk(dataOe == 1'b1, "R8 oe while sending", int'(dataOe), 1);
          if (rxMon) chk(dataOe == 1'b0, "R8 oe while receiving", int'(dataOe), 0);
          cap = {dataOut, cap[7:1]};
          bitCnt++;
          if (bitCnt == 8) begin
            if (txMon) begin
              txSeen[nSeen] = cap;
              nSeen++;
            end
            bitCnt = 0;
            haveByte = 1'b1;
          end
        end
        lastEdge = cyc;
        prevSclk = sclkOut;
      end
    end
  end

  task automatic doReset(input int newRl);
    @(negedge clk);
    rstN = 1'b0; txEn = 1'b0; rxEn = 1'b0; txValid = 1'b0; rxReady = 1'b0;
    gapChk = 1'b0; txMon = 1'b0; rxMon = 1'b0;
    reload = 13'(newRl); rl = newRl;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic sendBytes(input int n);
    for (int i = 0; i < n; i++) begin
      while (!txReady) @(negedge clk);
      txValid = 1'b1; txData = txPat(i);
      @(negedge clk);
      txValid = 1'b0;
      // R6: buffer holds the byte for at least the cycle after acceptance
      chk(txReady == 1'b0, "R6 ready drops after write", int'(txReady), 0);
    end
  endtask

  task automatic waitUntil(input int limit, ref int cnt, input int target);
    int stop = cyc + limit;
    while (cnt < target && cyc < stop) @(negedge clk);
  endtask

  task automatic runTx(input int newRl, input int n, input int mul, input int add);
    doReset(newRl);
    txMul = mul; txAdd = add;
    txMon = 1'b1; gapChk = 1'b1; txEn = 1'b1;
    sendBytes(n);
    waitUntil(20 * (newRl + 1) * (n + 2), nSeen, n);
    chk(nSeen == n, "R3 byte count", nSeen, n);
    for (int i = 0; i < n; i++)
      chk(txSeen[i] == txPat(i), "R3 transmitted byte", int'(txSeen[i]), int'(txPat(i)));
    repeat (4 * (newRl + 1)) @(negedge clk);
    chk(emptyCnt == n, "R6 empty pulses", emptyCnt, n);
    chk(dataOe == 1'b0, "R8 oe after stream", int'(dataOe), 0);
    chk(sclkOut == 1'b1, "R1 clock idle high after stream", int'(sclkOut), 1);
  endtask

  task automatic runRx(input int newRl, input int n, input int mul, input int add);
    int stop;
    doReset(newRl);
    rxMul = mul; rxAdd = add;
    rxMon = 1'b1; gapChk = 1'b1; rxReady = 1'b1; rxEn = 1'b1;
    stop = cyc + 20 * (newRl + 1) * (n + 2);
    while (riseCnt < 8 * n && cyc < stop) @(negedge clk);
    rxEn = 1'b0;
    waitUntil(40 * (newRl + 1), nGot, n);
    chk(nGot == n, "R4 received count", nGot, n);
    for (int i = 0; i < n; i++)
      chk(rxGot[i] == rxPat(i), "R4 received byte", int'(rxGot[i]), int'(rxPat(i)));
    chk(overrun == 1'b0, "R10 no overrun when read in time", int'(overrun), 0);
  endtask

  initial begin
    int e0;
    // R1: reset state
    doReset(0);
    chk(sclkOut == 1'b1, "R1 sclk", int'(sclkOut), 1);
    chk(dataOe == 1'b0, "R1 oe", int'(dataOe), 0);
    chk(txReady == 1'b1, "R1 txReady", int'(txReady), 1);
    chk(rxValid == 1'b0, "R1 rxValid", int'(rxValid), 0);
    chk(txEmpty == 1'b0, "R1 txEmpty", int'(txEmpty), 0);
    chk(overrun == 1'b0, "R1 overrun", int'(overrun), 0);

    // R3, R5, R6: every byte value, fastest rate
    runTx(0, 256, 1, 0);
    // R2, R5: slower rate, scrambled values
    runTx(2, 12, 37, 11);
    // R11: large reload
    runTx(300, 2, 91, 200);

    // R4, R5: every byte value received
    runRx(1, 256, 1, 0);
    runRx(3, 6, 53, 7);

    // R7: buffered byte waits with both enables low
    doReset(1);
    txMul = 1; txAdd = 8'hA5; txMon = 1'b1;
    sendBytes(1);
    e0 = edgeCnt;
    repeat (40) @(negedge clk);
    chk(edgeCnt == e0, "R7 no clock while disabled", edgeCnt - e0, 0);
    chk(sclkOut == 1'b1, "R7 clock high while disabled", int'(sclkOut), 1);
    chk(txReady == 1'b0, "R7 byte still buffered", int'(txReady), 0);
    txEn = 1'b1;
    waitUntil(200, nSeen, 1);
    chk(nSeen == 1 && txSeen[0] == 8'hA5, "R7 held byte sent", int'(txSeen[0]), 8'hA5);

    // R7: transmit wins over receive
    doReset(1);
    txMul = 1; txAdd = 8'h3C; txMon = 1'b1; rxReady = 1'b1;
    txEn = 1'b1; rxEn = 1'b1;
    sendBytes(1);
    waitUntil(200, nSeen, 1);
    chk(nSeen == 1 && txSeen[0] == 8'h3C, "R7 priority byte sent", int'(txSeen[0]), 8'h3C);
    repeat (8) @(negedge clk);
    chk(nGot == 0, "R7 nothing received under priority", nGot, 0);

    // R9, R10: hold, overrun and replacement
    doReset(0);
    rxMul = 3; rxAdd = 8'h5A; rxMon = 1'b1; rxReady = 1'b0; rxEn = 1'b1;
    waitUntil(200, riseCnt, 8);
    repeat (2) @(negedge clk);
    chk(rxValid == 1'b1, "R9 first byte valid", int'(rxValid), 1);
    chk(rxData == 8'h5A, "R4 first byte", int'(rxData), 8'h5A);
    chk(overrun == 1'b0, "R10 no overrun yet", int'(overrun), 0);
    waitUntil(200, riseCnt, 16);
    rxEn = 1'b0;
    repeat (2) @(negedge clk);
    chk(rxValid == 1'b1, "R9 still valid unread", int'(rxValid), 1);
    chk(overrun == 1'b1, "R10 overrun set", int'(overrun), 1);
    chk(rxData == 8'h5D, "R10 newer byte kept", int'(rxData), 8'h5D);
    repeat (10) @(negedge clk);
    chk(rxValid == 1'b1, "R9 valid held without ready", int'(rxValid), 1);
    rxReady = 1'b1;
    @(negedge clk);
    rxReady = 1'b0;
    chk(rxValid == 1'b0, "R9 valid cleared by ready", int'(rxValid), 0);
    chk(overrun == 1'b1, "R10 overrun sticky", int'(overrun), 1);
    chk(dataOe == 1'b0, "R8 oe idle after receive", int'(dataOe), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule